// File: doc/BRIEF.md
# Shared Cache Maintenance Command Queue

This block is the register front end through which several CPUs post cache maintenance work to a cache controller. A CPU sets a mode word that gives the operation (invalidate, clean or flush), the region (one address range or the whole cache) and a completion-notify request. For a range command it also writes a base address and a length. Commands from all CPUs enter one shared FIFO. A single executor takes them out in arrival order. The executor models execution time by staying busy for a programmable number of cycles. It does not model the cache arrays.

The mode, address and size registers are shared. A hardware lock protects them: the first CPU to write the mode register owns them, and it keeps them until it reads its registration-status register. An attempt by any other CPU in that time is rejected and flagged. Each CPU has its own registration flags (queue full, access denied), its own completion flag, and its own busy bits. With these, software can retry a rejected post and wait on its own commands. A read of the primitive-entry register works as a sync barrier: the read is not acknowledged until the queue and the executor are both empty.

Top module: `cmq_top`

## Requirements
- R1: Register offsets: 0x244 primitive entry, 0x248 mode, 0x24C address, 0x250 size, 0x25C registration status, 0x260 queue status. Each CPU reads its own copy of the status registers. Registration status returns bit 1 = full and bit 0 = denied. Queue status returns bit 2 = done, bit 1 = one of this CPU's commands is executing, bit 0 = this CPU has a command queued or executing.
- R2: A mode write takes the lock when it is free, or when the writer already holds it. A mode, address or size write from a CPU that is not the holder changes nothing and sets that CPU's denied flag. An address or size write while the lock is free is also denied.
- R3: The lock is released only when the holder reads its registration status. Any CPU's read of registration status clears that CPU's full and denied flags.
- R4: The mode word holds the region in bits 18:17 (0 range, 1 whole cache; 2 and 3 never enqueue), notify in bit 15, and the operation in bits 1:0 (0 invalidate, 1 clean, 2 flush). A whole-cache command is enqueued on the holder's mode write, with base and length 0. A range command is enqueued on the holder's size write, with the latched address as base and the written size as length.
- R5: When the FIFO already holds DEPTH commands, a post is dropped and the poster's full flag (bit 1) is set. The FIFO never holds more than DEPTH entries.
- R6: Commands execute one at a time in arrival order. A command starts in the cycle after it is at the head and the executor is idle. It occupies the executor for exec_lat+1 cycles. op_start pulses in its first cycle.
- R7: When a command with notify set retires, the done flag of the CPU that posted it is set. Commands without notify leave the flag unchanged. Writing 1 to bit 2 of queue status clears the writer's done flag. If a retire sets the flag in the same cycle, the set wins.
- R8: The queued and executing bits of queue status track only the reading CPU's own commands.
- R9: A read of the primitive entry is held without acknowledge while the FIFO is non-empty or the executor is busy. Writes to the primitive entry (code 8 sync, code 9 prefetch flush, or any other value) are acknowledged at once and enqueue nothing.
- R10: Every access other than a primitive-entry read is acknowledged in the cycle it is presented. Reads of unmapped or write-only offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request, held until bus_ack |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_ID_W | Identity of the accessing CPU |
| bus_addr | input | 12 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access accepted at the next rising edge |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high on a read |
| exec_lat | input | LAT_W | Extra busy cycles per command |
| op_start | output | 1 | First cycle of a command's execution |
| op_busy | output | 1 | Executor occupied |
| op_cpu | output | CPU_ID_W | CPU that posted the current command |
| op_kind | output | 2 | Operation of the current command |
| op_all | output | 1 | Current command covers the whole cache |
| op_base | output | 32 | Base address of the current command |
| op_len | output | 32 | Length of the current command |

## Verification
The main patterns are these:
- A single range command with notify. This shows that the size write triggers the post and that the done flag is set on retire.
- A whole-cache command from a second CPU while a third CPU tries the shared registers. This separates lock ownership from the per-CPU denied flags.
- A burst of posts under a long latency. This fills the FIFO, and the per-CPU busy bits and the full flag must separate the poster from idle CPUs.
- A mixed sequence of two range posts and a whole-cache post from different CPUs. This shows arrival ordering and field decoding at the executor.
- A sync read issued while work is outstanding. This shows the barrier stall.

Reserved region codes and prefetch-flush writes show that they enqueue nothing.

// File: rtl/cmq_pkg.sv
package cmq_pkg;

    localparam int ADDR_W   = 32;
    localparam int CPU_ID_W = 2;
    localparam int OFS_W    = 12;

    localparam logic [OFS_W-1:0] OFS_PRIM  = 12'h244;
    localparam logic [OFS_W-1:0] OFS_MODE  = 12'h248;
    localparam logic [OFS_W-1:0] OFS_ADDR  = 12'h24C;
    localparam logic [OFS_W-1:0] OFS_SIZE  = 12'h250;
    localparam logic [OFS_W-1:0] OFS_REGST = 12'h25C;
    localparam logic [OFS_W-1:0] OFS_QSTAT = 12'h260;

    typedef enum logic [1:0] {
        OP_INV   = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2,
        OP_RSVD  = 2'd3
    } maint_op_e;

    typedef enum logic [1:0] {
        RGN_RANGE = 2'd0,
        RGN_ALL   = 2'd1,
        RGN_RES2  = 2'd2,
        RGN_RES3  = 2'd3
    } region_e;

    typedef struct packed {
        region_e   region;
        logic      notify;
        maint_op_e op;
    } mode_t;

    typedef struct packed {
        logic [CPU_ID_W-1:0] cpu;
        region_e             region;
        logic                notify;
        maint_op_e           op;
        logic [ADDR_W-1:0]   base;
        logic [ADDR_W-1:0]   len;
    } maint_cmd_t;

    function automatic mode_t decode_mode(input logic [31:0] w);
        mode_t m;
        m.region = region_e'(w[18:17]);
        m.notify = w[15];
        m.op     = maint_op_e'(w[1:0]);
        return m;
    endfunction

endpackage

// File: rtl/cmq_fifo.sv
module cmq_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= step(wp);
            if (pop)  rp <= step(rp);
            cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    assign dout  = mem[rp];
    assign count = cnt;
    assign full  = (cnt == CNT_W'(DEPTH));
    assign empty = (cnt == '0);
endmodule

// File: rtl/cmq_exec.sv
module cmq_exec
    import cmq_pkg::*;
#(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             avail,
    input  maint_cmd_t       head,
    input  logic [LAT_W-1:0] lat,
    output logic             pop,
    output logic             start,
    output logic             busy,
    output logic             retire,
    output maint_cmd_t       cur
);
    logic [LAT_W-1:0] cnt;

    assign pop    = !busy && avail;
    assign retire = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            start <= 1'b0;
            cur   <= '0;
        end else begin
            start <= pop;
            if (pop) begin
                busy <= 1'b1;
                cnt  <= lat;
                cur  <= head;
            end else if (busy) begin
                if (cnt == '0) busy <= 1'b0;
                else           cnt  <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmq_top.sv
module cmq_top
    import cmq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LAT_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [CPU_ID_W-1:0] bus_cpu,
    input  logic [OFS_W-1:0]    bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic                bus_ack,
    output logic [31:0]         bus_rdata,
    input  logic [LAT_W-1:0]    exec_lat,
    output logic                op_start,
    output logic                op_busy,
    output logic [CPU_ID_W-1:0] op_cpu,
    output logic [1:0]          op_kind,
    output logic                op_all,
    output logic [ADDR_W-1:0]   op_base,
    output logic [ADDR_W-1:0]   op_len
);
    localparam int NCPU  = 1 << CPU_ID_W;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int CMD_W = $bits(maint_cmd_t);

    // FIFO and executor
    logic             push, pop, fifo_full, fifo_empty, retire;
    logic [CNT_W-1:0] fifo_count;
    maint_cmd_t       push_cmd, head_cmd, cur_cmd;
    logic [CMD_W-1:0] head_bits;

    cmq_fifo #(.DEPTH(DEPTH), .W(CMD_W)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .din(push_cmd), .pop(pop),
        .dout(head_bits), .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
    );
    assign head_cmd = maint_cmd_t'(head_bits);

    cmq_exec #(.LAT_W(LAT_W)) u_exec (
        .clk(clk), .rst(rst), .avail(!fifo_empty), .head(head_cmd), .lat(exec_lat),
        .pop(pop), .start(op_start), .busy(op_busy), .retire(retire), .cur(cur_cmd)
    );

    assign op_cpu  = cur_cmd.cpu;
    assign op_kind = cur_cmd.op;
    assign op_all  = (cur_cmd.region == RGN_ALL);
    assign op_base = cur_cmd.base;
    assign op_len  = cur_cmd.len;

    // access decode
    logic drained, acc, wr, rd;
    assign drained = fifo_empty && !op_busy;
    assign bus_ack = bus_req && !(!bus_we && (bus_addr == OFS_PRIM) && !drained);
    assign acc     = bus_req && bus_ack;
    assign wr      = acc && bus_we;
    assign rd      = acc && !bus_we;

    logic mode_wr, addr_wr, size_wr, regst_rd, qstat_wr;
    assign mode_wr  = wr && (bus_addr == OFS_MODE);
    assign addr_wr  = wr && (bus_addr == OFS_ADDR);
    assign size_wr  = wr && (bus_addr == OFS_SIZE);
    assign qstat_wr = wr && (bus_addr == OFS_QSTAT);
    assign regst_rd = rd && (bus_addr == OFS_REGST);

    // shared command registers and lock
    logic                lock_valid;
    logic [CPU_ID_W-1:0] lock_owner;
    mode_t               mode_q;
    logic [ADDR_W-1:0]   addr_q, size_q;
    mode_t               wmode;
    logic                is_owner, granted, shared_wr, want_push;

    assign wmode     = decode_mode(bus_wdata);
    assign is_owner  = lock_valid && (lock_owner == bus_cpu);
    assign shared_wr = mode_wr || addr_wr || size_wr;
    assign granted   = mode_wr ? (!lock_valid || is_owner) : is_owner;
    assign want_push = granted &&
                       ((mode_wr && wmode.region == RGN_ALL) ||
                        (size_wr && mode_q.region == RGN_RANGE));
    assign push      = want_push && !fifo_full;

    always_comb begin
        push_cmd.cpu = bus_cpu;
        if (mode_wr) begin
            push_cmd.region = wmode.region;
            push_cmd.notify = wmode.notify;
            push_cmd.op     = wmode.op;
            push_cmd.base   = '0;
            push_cmd.len    = '0;
        end else begin
            push_cmd.region = mode_q.region;
            push_cmd.notify = mode_q.notify;
            push_cmd.op     = mode_q.op;
            push_cmd.base   = addr_q;
            push_cmd.len    = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_valid <= 1'b0;
            lock_owner <= '0;
            mode_q     <= '0;
            addr_q     <= '0;
            size_q     <= '0;
        end else begin
            if (regst_rd && is_owner) begin
                lock_valid <= 1'b0;
            end else if (mode_wr && !lock_valid) begin
                lock_valid <= 1'b1;
                lock_owner <= bus_cpu;
            end
            if (granted && mode_wr) mode_q <= wmode;
            if (granted && addr_wr) addr_q <= bus_wdata;
            if (granted && size_wr) size_q <= bus_wdata;
        end
    end

    // per-CPU status
    logic [NCPU-1:0]  full_flag, deny_flag, done_flag;
    logic [CNT_W-1:0] pend [NCPU];

    always_ff @(posedge clk) begin
        if (rst) begin
            full_flag <= '0;
            deny_flag <= '0;
            done_flag <= '0;
            for (int i = 0; i < NCPU; i++) pend[i] <= '0;
        end else begin
            for (int i = 0; i < NCPU; i++) begin
                if (regst_rd && bus_cpu == CPU_ID_W'(i)) begin
                    full_flag[i] <= 1'b0;
                    deny_flag[i] <= 1'b0;
                end else begin
                    if (want_push && fifo_full && bus_cpu == CPU_ID_W'(i))
                        full_flag[i] <= 1'b1;
                    if (shared_wr && !granted && bus_cpu == CPU_ID_W'(i))
                        deny_flag[i] <= 1'b1;
                end
                if (retire && cur_cmd.notify && cur_cmd.cpu == CPU_ID_W'(i))
                    done_flag[i] <= 1'b1;
                else if (qstat_wr && bus_wdata[2] && bus_cpu == CPU_ID_W'(i))
                    done_flag[i] <= 1'b0;
                pend[i] <= pend[i]
                         + CNT_W'(push && bus_cpu == CPU_ID_W'(i))
                         - CNT_W'(retire && cur_cmd.cpu == CPU_ID_W'(i));
            end
        end
    end

    logic cur_pend_nz;
    assign cur_pend_nz = (pend[op_cpu] != '0);

    always_comb begin
        bus_rdata = '0;
        if (bus_req && !bus_we) begin
            case (bus_addr)
                OFS_REGST: bus_rdata[1:0] = {full_flag[bus_cpu], deny_flag[bus_cpu]};
                OFS_QSTAT: bus_rdata[2:0] = {done_flag[bus_cpu],
                                             op_busy && (op_cpu == bus_cpu),
                                             pend[bus_cpu] != '0};
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cmq_sva.sv
module cmq_sva
    import cmq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_req,
    input logic                bus_we,
    input logic                bus_ack,
    input logic [CPU_ID_W-1:0] bus_cpu,
    input logic [OFS_W-1:0]    bus_addr,
    input logic                lock_valid,
    input logic [CPU_ID_W-1:0] lock_owner,
    input logic [CNT_W-1:0]    fifo_count,
    input logic                fifo_full,
    input logic                push,
    input logic                op_start,
    input logic                op_busy,
    input logic                cur_pend_nz
);
    logic owner_release;
    assign owner_release = bus_req && bus_ack && !bus_we &&
                           (bus_addr == OFS_REGST) && (bus_cpu == lock_owner);

    AST_LOCK_KEPT: assert property (@(posedge clk) disable iff (rst)
        (lock_valid && !owner_release) |=> (lock_valid && lock_owner == $past(lock_owner))); // R3
    AST_LOCK_FREED: assert property (@(posedge clk) disable iff (rst)
        (lock_valid && owner_release) |=> !lock_valid); // R3
    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CNT_W'(DEPTH)); // R5
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !push); // R5
    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_addr == OFS_PRIM && (fifo_count != '0 || op_busy)) |-> !bus_ack); // R9
    AST_ACK_NOW: assert property (@(posedge clk) disable iff (rst)
        (bus_req && (bus_we || bus_addr != OFS_PRIM)) |-> bus_ack); // R10
    AST_START_GAP: assert property (@(posedge clk) disable iff (rst)
        op_start |=> !op_start); // R6
    AST_PEND_BUSY: assert property (@(posedge clk) disable iff (rst)
        op_busy |-> cur_pend_nz); // R8
endmodule

bind cmq_top cmq_sva #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_sva (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_ack(bus_ack),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .lock_valid(lock_valid),
    .lock_owner(lock_owner), .fifo_count(fifo_count), .fifo_full(fifo_full),
    .push(push), .op_start(op_start), .op_busy(op_busy), .cur_pend_nz(cur_pend_nz)
);

// File: tb/cmq_top_tb_top.sv
module cmq_top_tb_top;
    import cmq_pkg::*;

    localparam int DEPTH = 4;
    localparam int LAT_W = 8;
    localparam int NCPU  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic                bus_req = 1'b0, bus_we = 1'b0;
    logic [CPU_ID_W-1:0] bus_cpu = '0;
    logic [OFS_W-1:0]    bus_addr = '0;
    logic [31:0]         bus_wdata = '0;
    logic                bus_ack;
    logic [31:0]         bus_rdata;
    logic [LAT_W-1:0]    exec_lat = 8'd3;
    logic                op_start, op_busy, op_all;
    logic [CPU_ID_W-1:0] op_cpu;
    logic [1:0]          op_kind;
    logic [31:0]         op_base, op_len;

    cmq_top #(.DEPTH(DEPTH), .LAT_W(LAT_W)) dut_i (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_cpu(bus_cpu),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .exec_lat(exec_lat), .op_start(op_start), .op_busy(op_busy), .op_cpu(op_cpu),
        .op_kind(op_kind), .op_all(op_all), .op_base(op_base), .op_len(op_len)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int         m_owner;
    int         m_rgn, m_not, m_op;
    logic [31:0] m_addr;
    bit         m_full[NCPU], m_deny[NCPU], m_done[NCPU];
    int         m_pend[NCPU];
    maint_cmd_t q[$];
    bit         m_busy, m_start;
    int         m_cnt;
    maint_cmd_t m_cur;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_owner = -1; m_rgn = 0; m_not = 0; m_op = 0; m_addr = 0;
            for (int i = 0; i < NCPU; i++) begin
                m_full[i] = 0; m_deny[i] = 0; m_done[i] = 0; m_pend[i] = 0;
            end
            q.delete(); m_busy = 0; m_start = 0; m_cnt = 0; m_cur = '0;
        end else begin
            bit drained, acc, full, ret, dopush;
            int c;
            maint_cmd_t retc, nc;
            drained = (q.size() == 0) && !m_busy;
            acc  = bus_req && !(!bus_we && bus_addr == OFS_PRIM && !drained);
            full = (q.size() == DEPTH);
            ret  = m_busy && (m_cnt == 0);
            retc = m_cur;
            c    = int'(bus_cpu);
            dopush = 0;
            nc = '0;
            nc.cpu = bus_cpu;
            if (acc && bus_we) begin
                if (bus_addr == OFS_MODE) begin
                    if (m_owner < 0 || m_owner == c) begin
                        m_owner = c;
                        m_rgn = int'(bus_wdata[18:17]); m_not = int'(bus_wdata[15]); m_op = int'(bus_wdata[1:0]);
                        if (m_rgn == 1) begin
                            if (full) m_full[c] = 1;
                            else begin
                                dopush = 1; nc.region = RGN_ALL; nc.notify = m_not[0];
                                nc.op = maint_op_e'(m_op[1:0]);
                            end
                        end
                    end else m_deny[c] = 1;
                end else if (bus_addr == OFS_ADDR) begin
                    if (m_owner == c) m_addr = bus_wdata; else m_deny[c] = 1;
                end else if (bus_addr == OFS_SIZE) begin
                    if (m_owner == c) begin
                        if (m_rgn == 0) begin
                            if (full) m_full[c] = 1;
                            else begin
                                dopush = 1; nc.region = RGN_RANGE; nc.notify = m_not[0];
                                nc.op = maint_op_e'(m_op[1:0]); nc.base = m_addr; nc.len = bus_wdata;
                            end
                        end
                    end else m_deny[c] = 1;
                end else if (bus_addr == OFS_QSTAT) begin
                    if (bus_wdata[2]) m_done[c] = 0;
                end
            end
            if (acc && !bus_we && bus_addr == OFS_REGST) begin
                if (m_owner == c) m_owner = -1;
                m_full[c] = 0; m_deny[c] = 0;
            end
            m_start = 0;
            if (m_busy) begin
                if (m_cnt == 0) m_busy = 0; else m_cnt--;
            end else if (q.size() > 0) begin
                m_cur = q.pop_front(); m_busy = 1; m_cnt = int'(exec_lat); m_start = 1;
            end
            if (ret) begin
                m_pend[retc.cpu]--;
                if (retc.notify) m_done[retc.cpu] = 1;
            end
            if (dopush) begin q.push_back(nc); m_pend[c]++; end
        end
    end

    function automatic logic [31:0] exp_rd();
        int c = int'(bus_cpu);
        logic [31:0] r = '0;
        if (bus_addr == OFS_REGST) r[1:0] = {m_full[c], m_deny[c]};
        else if (bus_addr == OFS_QSTAT)
            r[2:0] = {m_done[c], m_busy && int'(m_cur.cpu) == c, m_pend[c] != 0};
        return r;
    endfunction

    // per-clock comparison against the model, away from the active edge
    logic [31:0] log_base[$];
    logic [1:0]  log_kind[$];
    logic        log_all[$];

    always @(negedge clk) begin
        if (!rst) begin
            bit eack;
            eack = bus_req && !(!bus_we && bus_addr == OFS_PRIM && !((q.size() == 0) && !m_busy));
            chk("R10/R9 ack", 32'(bus_ack), 32'(eack));
            if (bus_req && !bus_we && bus_ack) chk("R1 read data", bus_rdata, exp_rd());
            chk("R6 op_start", 32'(op_start), 32'(m_start));
            chk("R6 op_busy", 32'(op_busy), 32'(m_busy));
            if (m_busy) begin
                chk("R6 op_cpu", 32'(op_cpu), 32'(m_cur.cpu));
                chk("R4 op_kind", 32'(op_kind), 32'(m_cur.op));
                chk("R4 op_all", 32'(op_all), 32'(m_cur.region == RGN_ALL));
                chk("R4 op_base", op_base, m_cur.base);
                chk("R4 op_len", op_len, m_cur.len);
            end
            if (op_start) begin
                log_base.push_back(op_base); log_kind.push_back(op_kind); log_all.push_back(op_all);
            end
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bwr(input int cpu, input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_req = 1; bus_we = 1; bus_cpu = cpu[1:0]; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        while (!bus_ack) @(negedge clk);
        @(posedge clk); #2;
        bus_req = 0; bus_we = 0;
    endtask

    task automatic brd(input int cpu, input logic [11:0] a, output logic [31:0] d);
        @(posedge clk); #2;
        bus_req = 1; bus_we = 0; bus_cpu = cpu[1:0]; bus_addr = a; bus_wdata = 0;
        @(negedge clk);
        while (!bus_ack) @(negedge clk);
        d = bus_rdata;
        @(posedge clk); #2;
        bus_req = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired, actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int t0;
        repeat (4) @(posedge clk);
        #2 rst = 0;

        // reset state
        brd(0, OFS_QSTAT, v); chk("R1 reset qstat", v, 0);
        brd(0, OFS_REGST, v); chk("R1 reset regst", v, 0);

        // range flush with notify from cpu0
        bwr(0, OFS_MODE, (32'd0 << 17) | (32'd1 << 15) | 32'd2);
        bwr(0, OFS_ADDR, 32'h1000);
        bwr(0, OFS_SIZE, 32'h40);
        brd(0, OFS_REGST, v); chk("R3 owner regst", v, 0);
        idle(12);
        brd(0, OFS_QSTAT, v); chk("R7 done after notify", v, 32'h4);
        bwr(0, OFS_QSTAT, 32'h4);
        brd(0, OFS_QSTAT, v); chk("R7 done cleared", v, 0);

        // lock contention
        bwr(1, OFS_MODE, (32'd1 << 17) | 32'd0);
        bwr(2, OFS_MODE, (32'd1 << 17) | 32'd1);
        brd(2, OFS_REGST, v); chk("R2 denied flag", v, 32'h1);
        brd(2, OFS_REGST, v); chk("R3 clear on read", v, 0);
        brd(1, OFS_REGST, v); chk("R3 holder regst", v, 0);
        bwr(2, OFS_ADDR, 32'h5000);
        brd(2, OFS_REGST, v); chk("R2 addr write without lock", v, 32'h1);
        idle(12);
        brd(1, OFS_QSTAT, v); chk("R7 no notify no done", v, 0);

        // fill the queue
        exec_lat = 8'd40;
        for (int k = 0; k < 6; k++) bwr(0, OFS_MODE, (32'd1 << 17) | 32'd2);
        brd(0, OFS_REGST, v); chk("R5 full flag", v, 32'h2);
        brd(0, OFS_QSTAT, v); chk("R8 own busy bits", v, 32'h3);
        brd(3, OFS_QSTAT, v); chk("R8 other cpu idle", v, 0);

        // sync barrier
        bwr(1, OFS_PRIM, 32'd8);
        t0 = cyc;
        brd(1, OFS_PRIM, v);
        chk("R9 sync stalled", 32'((cyc - t0) > 100), 1);
        brd(0, OFS_QSTAT, v); chk("R9 drained after sync", v, 0);
        bwr(1, OFS_PRIM, 32'd9);
        idle(3);
        chk("R9 prefetch flush no command", 32'(op_busy), 0);
        brd(1, OFS_QSTAT, v); chk("R9 prefetch flush no pending", v, 0);

        // ordering across CPUs
        exec_lat = 8'd2;
        log_base.delete(); log_kind.delete(); log_all.delete();
        bwr(0, OFS_MODE, (32'd1 << 15) | 32'd0);
        bwr(0, OFS_ADDR, 32'h2000);
        bwr(0, OFS_SIZE, 32'h80);
        bwr(0, OFS_ADDR, 32'h3000);
        bwr(0, OFS_SIZE, 32'h100);
        brd(0, OFS_REGST, v);
        bwr(3, OFS_MODE, (32'd1 << 17) | 32'd1);
        brd(3, OFS_REGST, v); chk("R3 new holder after release", v, 0);
        idle(30);
        chk("R6 three commands", 32'(log_base.size()), 3);
        if (log_base.size() == 3) begin
            chk("R6 order first", log_base[0], 32'h2000);
            chk("R6 order second", log_base[1], 32'h3000);
            chk("R4 whole cache last", 32'(log_all[2]), 1);
            chk("R4 clean code", 32'(log_kind[2]), 1);
        end
        brd(0, OFS_QSTAT, v); chk("R7 done cpu0", v, 32'h4);
        brd(3, OFS_QSTAT, v); chk("R7 no done cpu3", v, 0);

        // reserved region never enqueues
        bwr(2, OFS_MODE, (32'd2 << 17) | 32'd2);
        bwr(2, OFS_SIZE, 32'h40);
        brd(2, OFS_REGST, v);
        idle(4);
        brd(2, OFS_QSTAT, v); chk("R4 reserved region", v, 0);

        // unmapped and write-only reads
        brd(1, 12'h100, v); chk("R10 unmapped read", v, 0);
        brd(1, OFS_MODE, v); chk("R10 mode read", v, 0);

        idle(4);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule